// File: doc/BRIEF.md
# Program Counter with Indirect ROM Sequencer

This block is the program-address unit of a small 4-bit controller. It keeps a 9-bit program counter and a two-entry return stack, and it runs two multi-cycle sequences. The first is an indirect jump, which replaces the low byte of the counter with a ROM word. The second is an indirect table load, which borrows the stack to visit a ROM word, copies that word into an 8-bit result register, and then resumes at the following instruction. Decode logic drives one strobe per instruction cycle. The block answers with the next ROM fetch address and with a busy flag that holds decode off during the second cycle of a sequence.

The counter always holds the address that follows the instruction now executing. Indirect addresses take their top bit from this already-advanced counter, and the accumulator and RAM digit supply the low eight bits. An indirect instruction in the last word of a page therefore reaches into the next page. At the last word of address 255 it reaches into the upper half of the program space. The ROM is synchronous: a word addressed in one cycle is presented on the data input in the next cycle.

Subroutine call, return and plain jump are present only as simple strobes. They exist so that the stack can be filled and emptied.

Top module: `prog_addr_unit`

## Requirements
- R1: While reset is low at a clock edge, the block clears the counter, both stack entries and the result register, and the busy flag is low after that edge.
- R2: A step strobe adds one to the counter. It counts in plain binary across page boundaries and wraps from 511 to 0.
- R3: A jump strobe loads the counter from the target address input. A call strobe does the same and also pushes: the old counter goes into the top entry and the old top entry goes into the lower entry. A return strobe loads the counter from the top entry and moves the lower entry up into the top entry.
- R4: In the cycle an indirect jump is issued, the ROM address output equals {counter bit 8, A, M}, with A in bits 7:4 and M in bits 3:0. The busy flag is high in the next cycle. After that second cycle, counter bits 7:0 hold the ROM word and bit 8 is unchanged.
- R5: An indirect load presents {counter bit 8, A, M} on the ROM address output in both of its cycles, and busy is high in the second cycle. After the second cycle, the result register holds the ROM word at that address and the counter is back to its value from before the load.
- R6: After an indirect load, the top stack entry is unchanged and the lower entry holds a copy of the top entry. The previous lower entry is lost.
- R7: A skip strobe advances the counter by one in a single cycle whatever other strobe comes with it. Busy stays low, and the result register and stack are untouched. The ROM address output shows the counter during that cycle.
- R8: Every strobe is ignored while busy is high.
- R9: An indirect operation issued when the counter has just crossed from 255 to 256 addresses the upper half, {1, A, M}, and the indirect jump keeps bit 8 set.
- R10: When several strobes come together, the first in this list wins: skip, indirect jump, indirect load, call, return, jump, step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_i | input | 1 | Normal one-word advance |
| skip_i | input | 1 | Current word is skipped |
| jid_i | input | 1 | Indirect jump issue |
| lqid_i | input | 1 | Indirect table load issue |
| call_i | input | 1 | Subroutine call (push and load) |
| ret_i | input | 1 | Subroutine return (pop) |
| load_i | input | 1 | Plain jump (load) |
| load_addr_i | input | 9 | Target for call and jump |
| a_i | input | 4 | Accumulator digit, indirect bits 7:4 |
| m_i | input | 4 | RAM digit, indirect bits 3:0 |
| rom_data_i | input | 8 | ROM word, one cycle after its address |
| rom_addr_o | output | 9 | ROM fetch address |
| pc_o | output | 9 | Program counter |
| q_o | output | 8 | Table-load result register |
| sa_o | output | 9 | Top stack entry |
| sb_o | output | 9 | Lower stack entry |
| busy_o | output | 1 | Second cycle of an indirect sequence |

## Verification
The indirect jump is swept over all 256 A/M pairs, once from a lower-half counter and once from an upper-half counter. This shows whether bit 8 comes from the counter or is lost, and whether A and M sit in the correct nibbles. The indirect load is swept over all 256 pairs with base and target addresses that change on every pass. A stale lower stack entry, or a counter that is not restored, therefore shows up as a mismatch. Further directed cases cover skips combined with each strobe, strobes driven during the busy cycle, strobe collisions, and counters at 255, 511 and a page edge.

// File: rtl/pa_pkg.sv
// Shared types for the program-address unit.
package pa_pkg;
    // Sequencer phase: idle, or the second cycle of an indirect operation.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_JUMP2 = 2'd1,
        SEQ_LOAD2 = 2'd2
    } seq_state_t;
endpackage

// File: rtl/pa_seq_ctrl.sv
// Indirect-operation sequencer.
// Starts a two-cycle indirect jump or indirect load when one is issued
// while idle and not skipped. Reports busy during the second cycle.
// Assumes: the skip strobe cancels an indirect issue; strobes while busy are dropped.
module pa_seq_ctrl
    import pa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       jid_i,
    input  logic       lqid_i,
    input  logic       skip_i,
    output seq_state_t state_o,
    output logic       busy_o,
    output logic       start_jump_o,
    output logic       start_load_o
);
    seq_state_t state_q;

    assign busy_o       = (state_q != SEQ_IDLE);
    assign start_jump_o = !busy_o && !skip_i && jid_i;
    assign start_load_o = !busy_o && !skip_i && !jid_i && lqid_i;
    assign state_o      = state_q;

    // Phase register: enter the second cycle on issue, always return to idle after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start_jump_o)      state_q <= SEQ_JUMP2;
                    else if (start_load_o) state_q <= SEQ_LOAD2;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // R4: an issued jump is followed by its second cycle
    a_r4_jump_second: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && jid_i && !skip_i) |=> (busy_o && state_q == SEQ_JUMP2));
    // R8: the busy cycle lasts exactly one cycle
    a_r8_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !busy_o);
    // R7: a skipped word never raises busy
    a_r7_skip_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && skip_i) |=> !busy_o);
endmodule

// File: rtl/pa_ret_stack.sv
// Two-entry return stack.
// Push moves the top entry down and writes the top. Pop moves the lower entry up.
// Assumes: push and pop are never requested together.
module pa_ret_stack #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] push_val_i,
    output logic [W-1:0] sa_o,
    output logic [W-1:0] sb_o
);
    logic [W-1:0] sa_q;
    logic [W-1:0] sb_q;

    assign sa_o = sa_q;
    assign sb_o = sb_q;

    // Stack entries: shift on push, lift on pop, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sa_q <= '0;
            sb_q <= '0;
        end else if (push_i) begin
            sa_q <= push_val_i;
            sb_q <= sa_q;
        end else if (pop_i) begin
            sa_q <= sb_q;
        end
    end

    // R3: push shifts the top entry down
    a_r3_push_shift: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (sb_o == $past(sa_o) && sa_o == $past(push_val_i)));
    // R3: pop lifts the lower entry
    a_r3_pop_lift: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> (sa_o == $past(sb_o)));
    // R6: the controller never pushes and pops in one cycle
    a_r6_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));
endmodule

// File: rtl/prog_addr_unit.sv
// Program-address unit: counter, return stack, indirect jump and indirect load.
// The counter holds the address after the executing word. Indirect addresses
// are {counter top bits, A, M}. The ROM returns data one cycle after its address.
// Assumes: PC_W > 2*NIB_W; the ROM word width is 2*NIB_W.
module prog_addr_unit
    import pa_pkg::*;
#(
    parameter int PC_W  = 9,
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_i,
    input  logic                 skip_i,
    input  logic                 jid_i,
    input  logic                 lqid_i,
    input  logic                 call_i,
    input  logic                 ret_i,
    input  logic                 load_i,
    input  logic [PC_W-1:0]      load_addr_i,
    input  logic [NIB_W-1:0]     a_i,
    input  logic [NIB_W-1:0]     m_i,
    input  logic [2*NIB_W-1:0]   rom_data_i,
    output logic [PC_W-1:0]      rom_addr_o,
    output logic [PC_W-1:0]      pc_o,
    output logic [2*NIB_W-1:0]   q_o,
    output logic [PC_W-1:0]      sa_o,
    output logic [PC_W-1:0]      sb_o,
    output logic                 busy_o
);
    localparam int LOW_W = 2 * NIB_W;

    seq_state_t       state_w;
    logic             busy_w;
    logic             start_jump_w;
    logic             start_load_w;
    logic [PC_W-1:0]  pc_q;
    logic [PC_W-1:0]  pc_d;
    logic [PC_W-1:0]  pc_inc;
    logic [PC_W-1:0]  ind_addr;
    logic [LOW_W-1:0] q_q;
    logic [PC_W-1:0]  sa_w;
    logic [PC_W-1:0]  sb_w;
    logic             plain_ok;
    logic             do_call;
    logic             do_ret;
    logic             push_w;
    logic             pop_w;

    pa_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .jid_i        (jid_i),
        .lqid_i       (lqid_i),
        .skip_i       (skip_i),
        .state_o      (state_w),
        .busy_o       (busy_w),
        .start_jump_o (start_jump_w),
        .start_load_o (start_load_w)
    );

    assign plain_ok = !busy_w && !skip_i && !jid_i && !lqid_i;
    assign do_call  = plain_ok && call_i;
    assign do_ret   = plain_ok && !call_i && ret_i;
    assign push_w   = start_load_w || do_call;
    assign pop_w    = (state_w == SEQ_LOAD2) || do_ret;

    pa_ret_stack #(.W(PC_W)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push_w),
        .pop_i      (pop_w),
        .push_val_i (pc_q),
        .sa_o       (sa_w),
        .sb_o       (sb_w)
    );

    assign pc_inc     = pc_q + PC_W'(1);
    assign ind_addr   = {pc_q[PC_W-1:LOW_W], a_i, m_i};
    assign rom_addr_o = (start_jump_w || start_load_w) ? ind_addr : pc_q;

    // Next counter value by sequence phase, then by strobe priority.
    always_comb begin
        pc_d = pc_q;
        if (state_w == SEQ_JUMP2) begin
            pc_d[LOW_W-1:0] = rom_data_i;
        end else if (state_w == SEQ_LOAD2) begin
            pc_d = sa_w;
        end else if (skip_i) begin
            pc_d = pc_inc;
        end else if (jid_i || lqid_i) begin
            pc_d = start_load_w ? ind_addr : pc_q;
        end else if (call_i) begin
            pc_d = load_addr_i;
        end else if (ret_i) begin
            pc_d = sa_w;
        end else if (load_i) begin
            pc_d = load_addr_i;
        end else if (step_i) begin
            pc_d = pc_inc;
        end
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // Result register: captures the ROM word in the second cycle of an indirect load.
    always_ff @(posedge clk) begin
        if (!rst_n)                      q_q <= '0;
        else if (state_w == SEQ_LOAD2)   q_q <= rom_data_i;
    end

    assign pc_o   = pc_q;
    assign q_o    = q_q;
    assign sa_o   = sa_w;
    assign sb_o   = sb_w;
    assign busy_o = busy_w;

    // R1: reset clears the visible state
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pc_o == '0 && q_o == '0 && sa_o == '0 && sb_o == '0 && !busy_o));
    // R2: a lone step adds one in plain binary
    a_r2_step_binary: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && step_i && !skip_i && !jid_i && !lqid_i && !call_i && !ret_i && !load_i)
        |=> pc_o == PC_W'($past(pc_o) + PC_W'(1)));
    // R7: a skip advances by one
    a_r7_skip_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && skip_i) |=> pc_o == PC_W'($past(pc_o) + PC_W'(1)));
    // R4: an indirect jump keeps the counter's top bits
    a_r4_jump_page: assert property (@(posedge clk) disable iff (!rst_n)
        start_jump_w |=> ##1 (pc_o[PC_W-1:LOW_W] == $past(pc_o[PC_W-1:LOW_W], 2)));
    // R5: an indirect load restores the counter
    a_r5_load_restore: assert property (@(posedge clk) disable iff (!rst_n)
        start_load_w |=> ##1 (pc_o == $past(pc_o, 2)));
    // R5: the result register changes only after a load's second cycle
    a_r5_q_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w != SEQ_LOAD2) |=> $stable(q_o));
    // R6: net stack effect of an indirect load
    a_r6_load_stack: assert property (@(posedge clk) disable iff (!rst_n)
        start_load_w |=> ##1 (sa_o == $past(sa_o, 2) && sb_o == $past(sa_o, 2)));
endmodule

// File: tb/prog_addr_unit_tb_top.sv
module prog_addr_unit_tb_top;
    localparam int PC_W  = 9;
    localparam int NIB_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_i = 0, skip_i = 0, jid_i = 0, lqid_i = 0;
    logic call_i = 0, ret_i = 0, load_i = 0;
    logic [PC_W-1:0]  load_addr_i = '0;
    logic [NIB_W-1:0] a_i = '0, m_i = '0;
    logic [7:0]       rom_data_i = '0;
    logic [PC_W-1:0]  rom_addr_o, pc_o, sa_o, sb_o;
    logic [7:0]       q_o;
    logic             busy_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    prog_addr_unit #(.PC_W(PC_W), .NIB_W(NIB_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .skip_i(skip_i),
        .jid_i(jid_i), .lqid_i(lqid_i), .call_i(call_i), .ret_i(ret_i),
        .load_i(load_i), .load_addr_i(load_addr_i), .a_i(a_i), .m_i(m_i),
        .rom_data_i(rom_data_i), .rom_addr_o(rom_addr_o), .pc_o(pc_o),
        .q_o(q_o), .sa_o(sa_o), .sb_o(sb_o), .busy_o(busy_o)
    );

    // ROM contents are computed; the top bit marks the half of the address space.
    function automatic logic [7:0] rom_word(input logic [8:0] ad);
        return (ad[7:0] * 8'd13) ^ {ad[8], 7'h35};
    endfunction

    // Synchronous ROM model.
    always @(posedge clk) rom_data_i <= rom_word(rom_addr_o);

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_in();
        step_i = 0; skip_i = 0; jid_i = 0; lqid_i = 0;
        call_i = 0; ret_i = 0; load_i = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_pc(input logic [8:0] v);
        idle_in(); load_i = 1; load_addr_i = v;
        tick(); idle_in();
    endtask

    task automatic run_jid(input logic [8:0] pcv, input logic [3:0] a, input logic [3:0] m);
        logic [8:0] ea;
        set_pc(pcv);
        ea = {pcv[8], a, m};
        a_i = a; m_i = m; jid_i = 1; #1;
        chk("R4 indirect jump address", rom_addr_o, ea);
        tick(); idle_in();
        chk("R4 jump busy second cycle", busy_o, 1);
        tick();
        chk("R4 jump busy cleared", busy_o, 0);
        chk("R4 jump target", pc_o, {pcv[8], rom_word(ea)});
    endtask

    task automatic run_lqid(input logic [8:0] b, input logic [8:0] t,
                            input logic [3:0] a, input logic [3:0] m);
        logic [8:0] ea;
        set_pc(b);
        call_i = 1; load_addr_i = t; tick(); idle_in();
        chk("R3 call push", sa_o, b);
        ea = {t[8], a, m};
        a_i = a; m_i = m; lqid_i = 1; #1;
        chk("R5 load address first cycle", rom_addr_o, ea);
        tick(); idle_in();
        chk("R5 load busy", busy_o, 1);
        chk("R5 load address second cycle", rom_addr_o, ea);
        tick();
        chk("R5 load result", q_o, rom_word(ea));
        chk("R5 load restores counter", pc_o, t);
        chk("R6 top entry kept", sa_o, b);
        chk("R6 lower entry copied", sb_o, b);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [8:0] s_sa, s_sb;
        logic [7:0] s_q;
        rst_n = 0; idle_in();
        tick(); tick();
        rst_n = 1;
        chk("R1 reset pc", pc_o, 0);
        chk("R1 reset sa", sa_o, 0);
        chk("R1 reset sb", sb_o, 0);
        chk("R1 reset q", q_o, 0);
        chk("R1 reset busy", busy_o, 0);

        // R2: stepping across a page edge and wrapping at the top
        set_pc(9'h03F); step_i = 1; tick(); idle_in();
        chk("R2 page edge step", pc_o, 9'h040);
        set_pc(9'h1FF); step_i = 1; tick(); idle_in();
        chk("R2 wrap", pc_o, 9'h000);
        set_pc(9'h0A0);
        chk("R3 jump load", pc_o, 9'h0A0);

        // R4: full A/M sweeps from both halves
        for (int i = 0; i < 256; i++) run_jid(9'h0A5, 4'(i >> 4), 4'(i));
        for (int i = 0; i < 256; i++) run_jid(9'h1C3, 4'(i >> 4), 4'(i));

        // R5, R6: load sweep with moving base and target
        for (int i = 0; i < 256; i++)
            run_lqid(9'(i * 3 + 5), {i[0], 8'(i * 7 + 16)}, 4'(i >> 4), 4'(i));

        // R3: return after a load uses the preserved top entry
        run_lqid(9'h077, 9'h150, 4'h3, 4'h9);
        ret_i = 1; tick(); idle_in();
        chk("R3 return pops", pc_o, 9'h077);
        chk("R3 return lifts lower", sa_o, 9'h077);

        // R9: counter just crossed from 255 into the upper half
        set_pc(9'h0FF); step_i = 1; tick(); idle_in();
        chk("R9 crossed counter", pc_o, 9'h100);
        a_i = 4'h2; m_i = 4'h3; jid_i = 1; #1;
        chk("R9 upper half address", rom_addr_o, 9'h123);
        tick(); idle_in(); tick();
        chk("R9 jump keeps bit 8", pc_o, {1'b1, rom_word(9'h123)});
        set_pc(9'h0FF); step_i = 1; tick(); idle_in();
        a_i = 4'h6; m_i = 4'h1; lqid_i = 1; #1;
        chk("R9 load upper half address", rom_addr_o, 9'h161);
        tick(); idle_in(); tick();
        chk("R9 load upper half word", q_o, rom_word(9'h161));

        // R7: skip with each indirect strobe and with a plain jump
        set_pc(9'h040);
        s_sa = sa_o; s_sb = sb_o; s_q = q_o;
        skip_i = 1; jid_i = 1; a_i = 4'hF; m_i = 4'hF; #1;
        chk("R7 skip address is counter", rom_addr_o, 9'h040);
        tick(); idle_in();
        chk("R7 skipped jump busy", busy_o, 0);
        chk("R7 skipped jump pc", pc_o, 9'h041);
        skip_i = 1; lqid_i = 1; tick(); idle_in();
        chk("R7 skipped load busy", busy_o, 0);
        chk("R7 skipped load pc", pc_o, 9'h042);
        chk("R7 skipped load q", q_o, s_q);
        chk("R7 skipped load sa", sa_o, s_sa);
        chk("R7 skipped load sb", sb_o, s_sb);
        skip_i = 1; load_i = 1; load_addr_i = 9'h155; call_i = 1; tick(); idle_in();
        chk("R10 skip beats jump and call", pc_o, 9'h043);
        chk("R7 skipped call sa", sa_o, s_sa);

        // R8: strobes in the busy cycle are ignored
        set_pc(9'h0C0);
        s_sa = sa_o; s_sb = sb_o; s_q = q_o;
        a_i = 4'h1; m_i = 4'h2; jid_i = 1; tick(); idle_in();
        step_i = 1; load_i = 1; load_addr_i = 9'h155; lqid_i = 1;
        call_i = 1; ret_i = 1; skip_i = 1; jid_i = 1;
        tick(); idle_in();
        chk("R8 jump unaffected", pc_o, {1'b0, rom_word(9'h012)});
        chk("R8 busy cleared", busy_o, 0);
        chk("R8 sa untouched", sa_o, s_sa);
        chk("R8 sb untouched", sb_o, s_sb);
        chk("R8 q untouched", q_o, s_q);

        // R10: priority among strobes
        set_pc(9'h120);
        jid_i = 1; lqid_i = 1; a_i = 4'h4; m_i = 4'h4; tick(); idle_in();
        chk("R10 jump beats load busy", busy_o, 1);
        tick();
        chk("R10 jump beats load pc", pc_o, {1'b1, rom_word(9'h144)});
        chk("R10 jump beats load q", q_o, s_q);
        set_pc(9'h010);
        load_i = 1; step_i = 1; load_addr_i = 9'h0E0; tick(); idle_in();
        chk("R10 jump beats step", pc_o, 9'h0E0);
        call_i = 1; load_i = 1; load_addr_i = 9'h033; tick(); idle_in();
        chk("R10 call pushes", sa_o, 9'h0E0);
        chk("R10 call loads", pc_o, 9'h033);
        ret_i = 1; load_i = 1; load_addr_i = 9'h1AA; tick(); idle_in();
        chk("R10 return beats jump", pc_o, 9'h0E0);

        // R1: reset during a busy cycle
        set_pc(9'h0C0);
        lqid_i = 1; tick(); idle_in();
        rst_n = 0; tick(); rst_n = 1;
        chk("R1 mid reset pc", pc_o, 0);
        chk("R1 mid reset busy", busy_o, 0);
        chk("R1 mid reset sa", sa_o, 0);
        chk("R1 mid reset q", q_o, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule